// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer placed on an APB peripheral bus. A 32-bit up-counter advances by one on each tick pulse while counting is switched on. The tick comes from one of two pulse inputs: an internal tick from a separate prescaler block, or an external periodic tick. When a tick arrives while the counter equals a programmable limit, three things happen at once. The counter restarts from zero, a sticky overflow flag is set, and a one-cycle system reset pulse is issued. The flag can also drive an interrupt, which software can mask.

Every register that shapes the watchdog's behaviour is write-guarded. A write to one of these registers takes effect only if the unlock word was written just before it. Each unlock grants exactly one guarded write. Software services the watchdog by setting a pet bit, which pins the counter at zero until software clears the bit again. Software clears the overflow flag by reading the flag register. The block exports its prescaler divisor for the external prescaler.

Top module: `apb_watchdog`

## Requirements
- R1: Registers are word-indexed by `paddr[4:2]` with `paddr[1:0]==0`: 0 config, 1 divisor, 2 count, 3 limit, 4 flag, 5 unlock, 6 pet. Index 7, misaligned addresses and the unlock register all read as zero. `pready` is always 1 and `pslverr` is always 0. After reset, every register reads 0 except the divisor, which reads 2.
- R2: Writing 0x5F3759DF to the unlock register arms the guard. Writing any other value there leaves the armed state unchanged. A write to config, divisor, limit or pet while the guard is disarmed is ignored.
- R3: An armed guard is consumed by the next write to config, divisor, limit or pet. A second guarded write then needs a fresh unlock. Writes to the count, flag or unmapped registers do not consume the guard.
- R4: The count register is read-only. It rises by one per selected tick while config bit 2 (run) is 1, and holds its value while run is 0.
- R5: Config bit 1 selects the tick source: 0 selects `tick_int_i`, 1 selects `tick_ext_i`.
- R6: A selected tick that arrives while running with count equal to the limit has three effects. The count is set to 0, the flag is set, and `sys_rst_o` is high for the one cycle after that edge.
- R7: Flag register bit 0 shows the overflow flag. An aligned read of the flag register clears it. A new overflow in the same cycle as the read wins, and the flag stays set.
- R8: `irq_o` is high exactly when the flag is set and config bit 0 (interrupt enable) is 1.
- R9: Pet register bit 0 reads back as written. While it is 1, the counter is held at 0 and no overflow occurs. Writing 0 lets counting resume.
- R10: The divisor register holds 20 bits and reads 0 above bit 19. Its value drives `prescale_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 5 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| tick_int_i | input | 1 | Tick pulse from the prescaler |
| tick_ext_i | input | 1 | External periodic tick pulse |
| irq_o | output | 1 | Masked overflow interrupt |
| sys_rst_o | output | 1 | One-cycle system reset pulse |
| prescale_o | output | 20 | Divisor value for the prescaler |

## Verification
The checker relies on two assumptions about the inputs. First, both tick inputs are already in the block's clock domain. Second, reset is held for at least one clock edge before its first release. The stimulus meets both assumptions: it drives the ticks and every bus signal on the falling clock edge, and it holds reset for three cycles.

Bus accesses follow the APB two-phase order with a single access phase each. They use only aligned addresses, so every write hits exactly one register.

The stimulus covers three tick cases: a tick every third cycle, a sparser external tick, and a limit of zero. The last case overflows on every tick and shows that back-to-back reset pulses are legal.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = 8;

    localparam logic [IDX_W-1:0] IDX_CFG  = 8'd0;
    localparam logic [IDX_W-1:0] IDX_DIV  = 8'd1;
    localparam logic [IDX_W-1:0] IDX_CNT  = 8'd2;
    localparam logic [IDX_W-1:0] IDX_LIM  = 8'd3;
    localparam logic [IDX_W-1:0] IDX_FLG  = 8'd4;
    localparam logic [IDX_W-1:0] IDX_KEY  = 8'd5;
    localparam logic [IDX_W-1:0] IDX_PET  = 8'd6;

    typedef struct packed {
        logic run;
        logic src_ext;
        logic irq_en;
    } wdt_cfg_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } wdt_acc_t;

    function automatic logic is_guarded(logic [IDX_W-1:0] idx);
        return (idx == IDX_CFG) || (idx == IDX_DIV) ||
               (idx == IDX_LIM) || (idx == IDX_PET);
    endfunction

    function automatic wdt_cfg_t cfg_unpack(logic [WORD_W-1:0] w);
        wdt_cfg_t c;
        c.run     = w[2];
        c.src_ext = w[1];
        c.irq_en  = w[0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_pack(wdt_cfg_t c);
        return {{(WORD_W-3){1'b0}}, c.run, c.src_ext, c.irq_en};
    endfunction

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import wdt_pkg::*;
#(
    parameter logic [WORD_W-1:0] MAGIC = 32'h5F37_59DF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] data,
    output logic              armed,
    output logic              grant
);
    logic key_ok;
    logic guarded_wr;

    assign key_ok     = wr && (idx == IDX_KEY) && (data == MAGIC);
    assign guarded_wr = wr && is_guarded(idx);
    assign grant      = guarded_wr && armed;

    always_ff @(posedge clk) begin
        if (rst)             armed <= 1'b0;
        else if (key_ok)     armed <= 1'b1;
        else if (guarded_wr) armed <= 1'b0;
    end
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int          CNT_W   = 32,
    parameter int          DIV_W   = 20,
    parameter int unsigned DIV_RST = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grant,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] data,
    input  logic [CNT_W-1:0]  count,
    input  logic              flag,
    output wdt_cfg_t          cfg,
    output logic [DIV_W-1:0]  div,
    output logic [CNT_W-1:0]  limit,
    output logic              pet,
    output logic [WORD_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            div   <= DIV_W'(DIV_RST);
            limit <= '0;
            pet   <= 1'b0;
        end else if (grant) begin
            case (idx)
                IDX_CFG: cfg   <= cfg_unpack(data);
                IDX_DIV: div   <= data[DIV_W-1:0];
                IDX_LIM: limit <= data[CNT_W-1:0];
                IDX_PET: pet   <= data[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            IDX_CFG: rdata = cfg_pack(cfg);
            IDX_DIV: rdata = WORD_W'(div);
            IDX_CNT: rdata = WORD_W'(count);
            IDX_LIM: rdata = WORD_W'(limit);
            IDX_FLG: rdata = WORD_W'(flag);
            IDX_PET: rdata = WORD_W'(pet);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             src_ext,
    input  logic             pet,
    input  logic [CNT_W-1:0] limit,
    input  logic             tick_int,
    input  logic             tick_ext,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             fire
);
    logic tick;
    logic step;
    logic hit;

    assign tick = src_ext ? tick_ext : tick_int;
    assign step = !pet && run && tick;
    assign hit  = step && (count == limit);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (pet)  count <= '0;
        else if (hit)  count <= '0;
        else if (step) count <= count + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) fire <= 1'b0;
        else     fire <= hit;
    end
endmodule

// File: rtl/apb_watchdog.sv
module apb_watchdog
    import wdt_pkg::*;
#(
    parameter int                ADDR_W  = 5,
    parameter int                CNT_W   = 32,
    parameter int                DIV_W   = 20,
    parameter int unsigned       DIV_RST = 2,
    parameter logic [WORD_W-1:0] MAGIC   = 32'h5F37_59DF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              tick_int_i,
    input  logic              tick_ext_i,
    output logic              irq_o,
    output logic              sys_rst_o,
    output logic [DIV_W-1:0]  prescale_o
);
    wdt_acc_t          acc;
    logic              aligned;
    logic              armed;
    logic              grant;
    wdt_cfg_t          cfg_q;
    logic [DIV_W-1:0]  div_q;
    logic [CNT_W-1:0]  limit_q;
    logic              pet_q;
    logic [CNT_W-1:0]  count;
    logic              flag;
    logic              fire;
    logic [WORD_W-1:0] rdata;

    assign aligned  = (paddr[1:0] == 2'b00);
    assign acc.wr   = psel && penable && pwrite && aligned;
    assign acc.rd   = psel && penable && !pwrite && aligned;
    assign acc.idx  = aligned ? IDX_W'(paddr[ADDR_W-1:2]) : IDX_W'(8'hFF);
    assign acc.data = pwdata;

    wdt_unlock #(.MAGIC(MAGIC)) u_unlock (
        .clk   (clk),
        .rst   (rst),
        .wr    (acc.wr),
        .idx   (acc.idx),
        .data  (acc.data),
        .armed (armed),
        .grant (grant)
    );

    wdt_regfile #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .grant (grant),
        .idx   (acc.idx),
        .data  (acc.data),
        .count (count),
        .flag  (flag),
        .cfg   (cfg_q),
        .div   (div_q),
        .limit (limit_q),
        .pet   (pet_q),
        .rdata (rdata)
    );

    wdt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (cfg_q.run),
        .src_ext  (cfg_q.src_ext),
        .pet      (pet_q),
        .limit    (limit_q),
        .tick_int (tick_int_i),
        .tick_ext (tick_ext_i),
        .flag_clr (acc.rd && (acc.idx == IDX_FLG)),
        .count    (count),
        .flag     (flag),
        .fire     (fire)
    );

    assign prdata     = rdata;
    assign pready     = 1'b1;
    assign pslverr    = 1'b0;
    assign irq_o      = flag && cfg_q.irq_en;
    assign sys_rst_o  = fire;
    assign prescale_o = div_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             pready,
    input logic             pslverr,
    input logic             fire,
    input logic             flag,
    input logic [CNT_W-1:0] count,
    input logic             run,
    input logic             pet,
    input logic             armed,
    input logic             grant
);
    assert_bus_ok_R1: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr);

    assert_consume_R3: assert property (@(posedge clk) disable iff (rst)
        grant |=> !armed);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!run && !pet) |=> $stable(count));

    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        fire |-> (flag && count == '0));

    assert_pet_R9: assert property (@(posedge clk) disable iff (rst)
        pet |=> (count == '0 && !fire));
endmodule

bind apb_watchdog wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pready  (pready),
    .pslverr (pslverr),
    .fire    (sys_rst_o),
    .flag    (flag),
    .count   (count),
    .run     (cfg_q.run),
    .pet     (pet_q),
    .armed   (armed),
    .grant   (grant)
);

// File: tb/apb_watchdog_test.sv
`timescale 1ns/1ps
module apb_watchdog_test;
    localparam logic [31:0] MAGIC = 32'h5F37_59DF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        tick_int_i = 1'b0, tick_ext_i = 1'b0;
    logic        ext_on = 1'b0;
    logic        irq_o, sys_rst_o;
    logic [19:0] prescale_o;

    int vectors = 0;
    int misses  = 0;
    int phase   = 0;

    // reference model state
    logic        m_run = 0, m_ext = 0, m_ien = 0, m_pet = 0, m_flag = 0, m_armed = 0, m_fire = 0;
    logic [19:0] m_div = 20'd2;
    logic [31:0] m_cnt = 0, m_lim = 0;

    always #2.5 clk = ~clk;

    apb_watchdog uut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .tick_int_i(tick_int_i), .tick_ext_i(tick_ext_i),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o), .prescale_o(prescale_o)
    );

    always @(negedge clk) begin
        phase      = (phase + 1) % 15;
        tick_int_i = (phase % 3 == 0);
        tick_ext_i = ext_on && (phase % 5 == 1);
    end

    function automatic logic [31:0] m_read(int idx);
        case (idx)
            0: return {29'b0, m_run, m_ext, m_ien};
            1: return {12'b0, m_div};
            2: return m_cnt;
            3: return m_lim;
            4: return {31'b0, m_flag};
            6: return {31'b0, m_pet};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_ext = 0; m_ien = 0; m_pet = 0; m_flag = 0;
            m_armed = 0; m_fire = 0; m_div = 20'd2; m_cnt = 0; m_lim = 0;
        end else begin
            logic tk, wr, rd, hit;
            int   ix;
            ix  = int'(paddr) / 4;
            wr  = psel && penable && pwrite;
            rd  = psel && penable && !pwrite;
            tk  = m_ext ? tick_ext_i : tick_int_i;
            hit = 0;
            if (m_pet) m_cnt = 0;
            else if (m_run && tk) begin
                if (m_cnt == m_lim) begin m_cnt = 0; hit = 1; end
                else m_cnt = m_cnt + 1;
            end
            m_fire = hit;
            if (hit) m_flag = 1;
            else if (rd && ix == 4) m_flag = 0;
            if (wr) begin
                if (ix == 5) begin
                    if (pwdata == MAGIC) m_armed = 1;
                end else if (ix == 0 || ix == 1 || ix == 3 || ix == 6) begin
                    if (m_armed) begin
                        case (ix)
                            0: begin m_run = pwdata[2]; m_ext = pwdata[1]; m_ien = pwdata[0]; end
                            1: m_div = pwdata[19:0];
                            3: m_lim = pwdata;
                            default: m_pet = pwdata[0];
                        endcase
                    end
                    m_armed = 0;
                end
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison of the outputs
    always @(negedge clk) begin
        if (!rst) begin
            check("R6 sys_rst_o", {31'b0, sys_rst_o}, {31'b0, m_fire});
            check("R8 irq_o", {31'b0, irq_o}, {31'b0, m_flag & m_ien});
            check("R10 prescale_o", {12'b0, prescale_o}, {12'b0, m_div});
            check("R1 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
        end
    end

    task automatic bus_wr(int idx, logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; penable = 0; paddr = 5'(idx * 4); pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(int idx, string tag);
        @(negedge clk);
        psel = 1; pwrite = 0; penable = 0; paddr = 5'(idx * 4);
        @(negedge clk);
        penable = 1;
        #1 check(tag, prdata, m_read(idx));
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic guarded(int idx, logic [31:0] d);
        bus_wr(5, MAGIC);
        bus_wr(idx, d);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: run did not finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        idle(3);
        rst = 0;
        // R1: reset values and unmapped reads
        for (int i = 0; i < 8; i++) bus_rd(i, "R1 reset/map");
        // R2: guard disarmed or wrong key
        bus_wr(0, 32'h7);
        bus_rd(0, "R2 unkeyed write ignored");
        bus_wr(5, 32'h1234_5678);
        bus_wr(3, 32'h9);
        bus_rd(3, "R2 wrong key ignored");
        // R3: single-use unlock
        guarded(3, 32'h4);
        bus_rd(3, "R3 keyed write lands");
        bus_wr(3, 32'h8);
        bus_rd(3, "R3 second write ignored");
        // R2: wrong key does not disarm; R10 divisor width
        bus_wr(5, MAGIC);
        bus_wr(5, 32'h0);
        bus_wr(1, 32'hFFFF_FFFF);
        bus_rd(1, "R10 divisor upper bits zero");
        // R3: count write does not consume the guard
        bus_wr(5, MAGIC);
        bus_wr(2, 32'h55);
        bus_wr(1, 32'h0_0123);
        bus_rd(1, "R3 guard kept across count write");
        // R4/R6/R8: run on internal tick with interrupt enabled
        guarded(0, 32'h5);
        for (int i = 0; i < 6; i++) begin
            idle(4);
            bus_rd(2, "R4 counting");
        end
        bus_rd(4, "R7 flag set");
        bus_rd(4, "R7 flag cleared by read");
        // R9: pet holds the counter at zero
        guarded(6, 32'h1);
        idle(20);
        bus_rd(2, "R9 held at zero");
        bus_rd(6, "R9 pet readback");
        guarded(6, 32'h0);
        idle(9);
        bus_rd(2, "R9 resumed");
        // R5: external tick source
        ext_on = 1;
        guarded(0, 32'h7);
        for (int i = 0; i < 5; i++) begin
            idle(7);
            bus_rd(2, "R5 external tick");
        end
        // R4: stopped counter holds
        guarded(0, 32'h2);
        bus_rd(2, "R4 stopped");
        idle(10);
        bus_rd(2, "R4 still held");
        bus_wr(2, 32'hAB);
        bus_rd(2, "R4 count read-only");
        // R6: limit zero overflows on every tick
        ext_on = 0;
        guarded(3, 32'h0);
        guarded(0, 32'h5);
        idle(15);
        bus_rd(4, "R7 flag after zero limit");
        bus_rd(0, "R1 config readback");
        idle(3);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule